// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port for a host that moves one word at a time. On the transmit side the host writes a word into a one-entry holding register. The word then moves into a shift register that sends a start bit, the data bits LSB first, an optional parity bit and one or two stop bits. On the receive side the line is synchronised and sampled 16 times per bit. A frame is accepted only if its start bit still reads low at the bit centre. Each bit is resolved by a 2-of-3 vote over three samples taken around the bit centre. The finished word is placed in a one-entry receive buffer together with its error flags.

A word can be 5 to 9 bits long. In multiprocessor mode the final data bit marks the frame type: 1 for an address frame and 0 for a data frame. While the mode is on, the receiver keeps only address frames and drops every data frame silently. The host checks the address and turns the mode off when it is the addressed node. Bit timing comes from an external enable, `baud_tick`, which runs at 16 times the bit rate.

Top module: `serial_mp_xcvr`

## Requirements
- R1: `cfg_len` selects the data length: codes 0..4 give 5..9 bits, and codes 5..7 give 9 bits. A frame is a low start bit, then the data LSB first, then high stop bits. The idle line is high.
- R2: Every bit on `txd` lasts exactly 16 `baud_tick` pulses. `cfg_two_stop`=1 sends two stop bits and 0 sends one.
- R3: `cfg_par` selects parity: 2'b00 or 2'b01 means none, 2'b10 even, 2'b11 odd. The parity bit follows the last data bit. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R4: The receiver sets `rx_perr` with the word when the received parity bit does not match the parity computed from the received data.
- R5: If the first stop bit samples low, the word is still delivered and `rx_ferr` is set with it.
- R6: If a frame completes while `irq_rxc` is high and no read is made in that cycle, the buffered word and its flags are kept, the new frame is lost, and `rx_ovr` goes high.
- R7: A low pulse on `rxd` that is high again by the bit centre is discarded as a false start. No word is delivered.
- R8: Each received bit is the majority of the samples at oversample counts 7, 8 and 9, so a single-cycle glitch at the centre does not change the bit.
- R9: With `cfg_mp_en`=1, a frame whose final data bit is 0 is dropped and leaves the buffer and flags unchanged. A frame whose final data bit is 1 is stored.
- R10: A word written while a frame is being sent starts its start bit on the cycle right after the last stop bit ends, with no idle bit between frames.
- R11: `irq_dre` is high exactly when the holding register is empty. A `tx_wr` while `irq_dre` is low is ignored.
- R12: `irq_txc` goes high when the last stop bit ends and no word is queued. It stays high until a cycle with `txc_clear`=1.
- R13: After reset, `txd`=1, `irq_dre`=1, `irq_txc`=0 and `irq_rxc`=0.
- R14: A cycle with `rd_strobe`=1 while `irq_rxc` is high empties the buffer: `irq_rxc`, `rx_ferr`, `rx_perr` and `rx_ovr` are low on the next cycle unless a new frame completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversample enable, 16 per bit |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 2 | Parity mode |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_mp_en | input | 1 | Multiprocessor address filter enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 9 | Word to send |
| irq_dre | output | 1 | Transmit holding register empty |
| irq_txc | output | 1 | Sticky transmit-complete flag |
| txc_clear | input | 1 | Write-one clear of `irq_txc` |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rd_strobe | input | 1 | Consumes the buffered received word |
| rx_data | output | 9 | Buffered received word, unused high bits zero |
| rx_ferr | output | 1 | Framing error of the buffered word |
| rx_perr | output | 1 | Parity error of the buffered word |
| rx_ovr | output | 1 | A later frame was lost while this word waited |
| irq_rxc | output | 1 | Receive buffer holds a word |

## Verification
The bench sweeps every data length, parity mode and stop length through a loopback. It measures each frame from the falling edge of the start bit to `irq_txc` against 16 times the computed bit count. A miscounted parity or stop bit shows up there as a length error of 16 cycles. Hand-built frames then carry:
- a bad parity bit, which a receiver that checks the wrong sense flags on a good frame;
- a low stop bit;
- a short false start, which a receiver without centre validation turns into a spurious word;
- single-cycle glitches at bit centres, which a receiver that uses one sample reads as the wrong bit.

Further tests check overrun retention, address filtering at 9 and 7 bits, back-to-back timing with no gap, and a write to a full holding register that must leave no trace on the line.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int MAX_BITS = 9;
  localparam int FRAME_W  = MAX_BITS + 4;

  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;

  function automatic logic [3:0] data_len(input logic [2:0] code);
    return (code > 3'd4) ? 4'd9 : ({1'b0, code} + 4'd5);
  endfunction

  function automatic logic par_bit(input logic [MAX_BITS-1:0] d,
                                   input logic [3:0] n,
                                   input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(n)) p = p ^ d[i];
    return p;
  endfunction
endpackage

// File: rtl/smx_sync.sv
module smx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/smx_tx.sv
module smx_tx
  import smx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [2:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  input  logic                wr,
  input  logic [MAX_BITS-1:0] wdata,
  input  logic                txc_clr,
  output logic                txd,
  output logic                dre,
  output logic                txc,
  output logic                busy
);
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(FRAME_W + 1);

  logic [MAX_BITS-1:0] hold;
  logic                hold_full;
  logic [FRAME_W-1:0]  sr;
  logic [NW-1:0]       remain;
  logic [CW-1:0]       cnt;
  logic                busy_q, txd_q, txc_q;

  logic [3:0]          n;
  logic                par_en;
  logic [FRAME_W-1:0]  frame;
  logic [NW-1:0]       total;
  logic                bit_end, frame_end, load;

  always_comb begin
    n      = data_len(cfg_len);
    par_en = cfg_par[1];
    frame  = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(n)) frame[i+1] = hold[i];
    if (par_en) frame[int'(n)+1] = par_bit(hold, n, cfg_par[0]);
    total = NW'(1 + int'(n) + (par_en ? 1 : 0) + (cfg_two_stop ? 2 : 1));
  end

  assign bit_end   = busy_q && tick && (cnt == CW'(OSR-1));
  assign frame_end = bit_end && (remain == '0);
  assign load      = hold_full && (!busy_q || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      sr        <= '1;
      remain    <= '0;
      cnt       <= '0;
      busy_q    <= 1'b0;
      txd_q     <= 1'b1;
      txc_q     <= 1'b0;
    end else begin
      if (load)
        hold_full <= 1'b0;
      else if (wr && !hold_full) begin
        hold      <= wdata;
        hold_full <= 1'b1;
      end

      if (load) begin
        sr     <= frame >> 1;
        remain <= total - NW'(1);
        cnt    <= '0;
        busy_q <= 1'b1;
        txd_q  <= 1'b0;
      end else if (busy_q && tick) begin
        if (cnt == CW'(OSR-1)) begin
          cnt <= '0;
          if (remain == '0) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
          end else begin
            txd_q  <= sr[0];
            sr     <= sr >> 1;
            remain <= remain - NW'(1);
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end

      if (frame_end && !hold_full) txc_q <= 1'b1;
      else if (txc_clr)            txc_q <= 1'b0;
    end
  end

  assign txd  = txd_q;
  assign dre  = !hold_full;
  assign txc  = txc_q;
  assign busy = busy_q;
endmodule

// File: rtl/smx_rx.sv
module smx_rx
  import smx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rxd_s,
  input  logic [2:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_mp_en,
  output logic                push,
  output logic [MAX_BITS-1:0] pdata,
  output logic                pferr,
  output logic                pperr
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_st_e;

  rx_st_e              st;
  logic [CW-1:0]       cnt;
  logic                s_a, s_b, par_rx;
  logic [3:0]          idx;
  logic [MAX_BITS-1:0] word;

  logic [3:0] n;
  logic       maj, at_mid, at_end, last_data;

  always_comb begin
    n         = data_len(cfg_len);
    maj       = (s_a & s_b) | (s_a & rxd_s) | (s_b & rxd_s);
    at_mid    = tick && (cnt == CW'(MID+1));
    at_end    = tick && (cnt == CW'(OSR-1));
    last_data = (idx == n - 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      par_rx <= 1'b0;
      idx    <= '0;
      word   <= '0;
      push   <= 1'b0;
      pdata  <= '0;
      pferr  <= 1'b0;
      pperr  <= 1'b0;
    end else begin
      push <= 1'b0;
      if (st == S_IDLE) begin
        if (tick && !rxd_s) begin
          st   <= S_START;
          cnt  <= '0;
          idx  <= '0;
          word <= '0;
        end
      end else if (tick) begin
        cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + CW'(1);
        if (cnt == CW'(MID-1)) s_a <= rxd_s;
        if (cnt == CW'(MID))   s_b <= rxd_s;

        if (at_mid) begin
          case (st)
            S_START: if (maj) st <= S_IDLE;
            S_DATA:  word[idx] <= maj;
            S_PAR:   par_rx <= maj;
            S_STOP: begin
              push  <= !(cfg_mp_en && !word[n - 4'd1]);
              pdata <= word;
              pferr <= !maj;
              pperr <= cfg_par[1] && (par_rx != par_bit(word, n, cfg_par[0]));
              st    <= S_IDLE;
            end
            default: ;
          endcase
        end

        if (at_end) begin
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              if (last_data) st <= cfg_par[1] ? S_PAR : S_STOP;
              else           idx <= idx + 4'd1;
            end
            S_PAR:   st <= S_STOP;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smx_rx_buf.sv
module smx_rx_buf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pferr,
  input  logic          pperr,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          perr,
  output logic          ovr,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
      ovr   <= 1'b0;
      valid <= 1'b0;
    end else if (push && (!valid || rd)) begin
      data  <= pdata;
      ferr  <= pferr;
      perr  <= pperr;
      ovr   <= 1'b0;
      valid <= 1'b1;
    end else if (push) begin
      ovr <= 1'b1;
    end else if (rd && valid) begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
      ovr   <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_mp_xcvr.sv
module serial_mp_xcvr
  import smx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic [2:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  input  logic                cfg_mp_en,
  input  logic                tx_wr,
  input  logic [MAX_BITS-1:0] tx_wdata,
  output logic                irq_dre,
  output logic                irq_txc,
  input  logic                txc_clear,
  output logic                txd,
  input  logic                rxd,
  input  logic                rd_strobe,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_ferr,
  output logic                rx_perr,
  output logic                rx_ovr,
  output logic                irq_rxc
);
  logic                tx_busy;
  logic                rxd_s;
  logic                rx_push, rx_pferr, rx_pperr;
  logic [MAX_BITS-1:0] rx_pdata;

  smx_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
    .wr(tx_wr), .wdata(tx_wdata), .txc_clr(txc_clear),
    .txd(txd), .dre(irq_dre), .txc(irq_txc), .busy(tx_busy)
  );

  smx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
  );

  smx_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd_s(rxd_s),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_mp_en(cfg_mp_en),
    .push(rx_push), .pdata(rx_pdata), .pferr(rx_pferr), .pperr(rx_pperr)
  );

  smx_rx_buf #(.DW(MAX_BITS)) u_buf (
    .clk(clk), .rst(rst), .push(rx_push), .pdata(rx_pdata),
    .pferr(rx_pferr), .pperr(rx_pperr), .rd(rd_strobe),
    .data(rx_data), .ferr(rx_ferr), .perr(rx_perr), .ovr(rx_ovr),
    .valid(irq_rxc)
  );
endmodule

// File: rtl/smx_checker.sv
module smx_checker (
  input logic       clk,
  input logic       rst,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_wr,
  input logic       irq_dre,
  input logic       irq_txc,
  input logic       txc_clear,
  input logic       irq_rxc,
  input logic       rd_strobe,
  input logic [8:0] rx_data,
  input logic       rx_ferr,
  input logic       rx_perr,
  input logic       rx_ovr
);
  // R1: line rests at mark whenever no frame is in flight
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R11: an accepted write fills the holding register
  p_dre_write_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && irq_dre) |=> !irq_dre);

  // R12: transmit-complete is sticky until cleared
  p_txc_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_txc && !txc_clear) |=> irq_txc);

  // R14: an unread word and its flags stay put
  p_rx_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (irq_rxc && !rd_strobe) |=> (irq_rxc && $stable(rx_data)
                                 && $stable(rx_ferr) && $stable(rx_perr)));

  // R6: overrun only ever marks a word that is still held
  p_ovr_held_r6: assert property (@(posedge clk) disable iff (rst)
    rx_ovr |-> irq_rxc);

  // R6: overrun stays set until the word is read
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !rd_strobe) |=> rx_ovr);
endmodule

bind serial_mp_xcvr smx_checker u_chk (
  .clk(clk), .rst(rst), .txd(txd), .tx_busy(tx_busy), .tx_wr(tx_wr),
  .irq_dre(irq_dre), .irq_txc(irq_txc), .txc_clear(txc_clear),
  .irq_rxc(irq_rxc), .rd_strobe(rd_strobe), .rx_data(rx_data),
  .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr)
);

// File: tb/serial_mp_xcvr_test.sv
`timescale 1ns/1ps
module serial_mp_xcvr_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, baud_tick = 1'b1;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_two_stop = 1'b0, cfg_mp_en = 1'b0;
  logic       tx_wr = 1'b0, txc_clear = 1'b0, rd_strobe = 1'b0;
  logic [8:0] tx_wdata = '0;
  logic       irq_dre, irq_txc, txd, irq_rxc, rx_ferr, rx_perr, rx_ovr;
  logic [8:0] rx_data;
  logic       loop_en = 1'b1, drv_rxd = 1'b1;
  wire        rxd = loop_en ? txd : drv_rxd;

  serial_mp_xcvr uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .cfg_mp_en(cfg_mp_en),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .irq_dre(irq_dre), .irq_txc(irq_txc),
    .txc_clear(txc_clear), .txd(txd), .rxd(rxd), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr),
    .irq_rxc(irq_rxc)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vec = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int nbits(input int code);
    return (code > 4) ? 9 : code + 5;
  endfunction

  task automatic send(input logic [8:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx;
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic clear_txc;
    @(negedge clk); txc_clear = 1'b1;
    @(negedge clk); txc_clear = 1'b0;
  endtask

  task automatic wait_low(output int t);
    while (txd !== 1'b0) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_txc(output int t);
    while (irq_txc !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  // drive one raw frame on rxd; bits in gmask get a 1-cycle flip at the centre
  task automatic raw_frame(input logic [15:0] bits, input int nb, input logic [15:0] gmask);
    for (int i = 0; i < nb; i++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        drv_rxd = bits[i] ^ (gmask[i] && c == 8);
      end
    @(negedge clk); drv_rxd = 1'b1;
    step(40);
  endtask

  task automatic xfer(input logic [8:0] d, input int code, input int par, input int two);
    int t0, t1, n, tb, expd;
    n    = nbits(code);
    tb   = 1 + n + (par >= 2 ? 1 : 0) + (two ? 2 : 1);
    expd = int'(d) & ((1 << n) - 1);
    send(d);
    wait_low(t0);
    wait_txc(t1);
    chk(t1 - t0 == 16 * tb, "R2 frame duration", t1 - t0, 16 * tb);
    chk(irq_rxc == 1'b1, "R1 word received", int'(irq_rxc), 1);
    chk(int'(rx_data) == expd, "R1 loopback data", int'(rx_data), expd);
    chk(rx_perr == 1'b0, "R3 parity agrees", int'(rx_perr), 0);
    chk(rx_ferr == 1'b0, "R5 no framing error", int'(rx_ferr), 0);
    read_rx;
    chk(irq_rxc == 1'b0, "R14 read empties buffer", int'(irq_rxc), 0);
    step(3);
    chk(irq_txc == 1'b1, "R12 txc sticky", int'(irq_txc), 1);
    clear_txc;
    chk(irq_txc == 1'b0, "R12 txc cleared", int'(irq_txc), 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    summary;
  end

  initial begin
    logic [8:0] pats [4];
    int t0, t1, n;
    logic [15:0] fb;
    logic [7:0] d8;
    pats[0] = 9'h1A5; pats[1] = 9'h05A; pats[2] = 9'h1FF; pats[3] = 9'h000;

    step(4);
    rst = 1'b0;
    step(2);
    // R13: reset state
    chk(txd == 1'b1, "R13 txd idle", int'(txd), 1);
    chk(irq_dre == 1'b1, "R13 dre", int'(irq_dre), 1);
    chk(irq_txc == 1'b0, "R13 txc", int'(irq_txc), 0);
    chk(irq_rxc == 1'b0, "R13 rxc", int'(irq_rxc), 0);

    // R1 R2 R3 sweep of all formats through loopback
    for (int code = 0; code < 5; code++)
      for (int pi = 0; pi < 3; pi++)
        for (int two = 0; two < 2; two++) begin
          @(negedge clk);
          cfg_len = 3'(code);
          cfg_par = (pi == 0) ? 2'b00 : (pi == 1) ? 2'b10 : 2'b11;
          cfg_two_stop = two[0];
          for (int k = 0; k < 4; k++)
            xfer(pats[k] ^ 9'(code * 37), code, int'(cfg_par), two);
        end

    // R10 R11: back-to-back frames, write while full ignored
    @(negedge clk); cfg_len = 3'd3; cfg_par = 2'b00; cfg_two_stop = 1'b0;
    send(9'h0C3);
    wait_low(t0);
    send(9'h03C);
    chk(irq_dre == 1'b0, "R11 dre low when queued", int'(irq_dre), 0);
    send(9'h0FF);
    begin
      logic [8:0] got;
      got = '0;
      while (cyc < t0 + 159) begin
        @(negedge clk);
        if (irq_rxc && !rd_strobe) begin got = rx_data; rd_strobe = 1'b1; end
        else rd_strobe = 1'b0;
      end
      rd_strobe = 1'b0;
      chk(txd == 1'b1, "R10 stop bit before next start", int'(txd), 1);
      @(negedge clk);
      chk(txd == 1'b0, "R10 next start without gap", int'(txd), 0);
      chk(irq_txc == 1'b0, "R12 no txc between queued frames", int'(irq_txc), 0);
      chk(got == 9'h0C3, "R10 first word", int'(got), 'h0C3);
    end
    wait_txc(t1);
    chk(t1 - t0 == 320, "R10 two frames back to back", t1 - t0, 320);
    chk(rx_data == 9'h03C, "R11 queued word delivered", int'(rx_data), 'h03C);
    read_rx;
    step(400);
    chk(irq_rxc == 1'b0, "R11 ignored write sends nothing", int'(irq_rxc), 0);
    chk(irq_dre == 1'b1, "R11 dre high when empty", int'(irq_dre), 1);
    clear_txc;

    // R6 overrun
    send(9'h011); wait_txc(t1); clear_txc;
    send(9'h022); wait_txc(t1); clear_txc;
    step(2);
    chk(rx_data == 9'h011, "R6 held word kept", int'(rx_data), 'h011);
    chk(rx_ovr == 1'b1, "R6 overrun flag", int'(rx_ovr), 1);
    read_rx;
    chk(rx_ovr == 1'b0, "R14 overrun cleared on read", int'(rx_ovr), 0);
    xfer(9'h0A5, 3, 0, 0);

    // R9 multiprocessor filter, 9-bit frames
    @(negedge clk); cfg_len = 3'd4; cfg_mp_en = 1'b1;
    send(9'h055); wait_txc(t1); clear_txc; step(10);
    chk(irq_rxc == 1'b0, "R9 data frame dropped", int'(irq_rxc), 0);
    send(9'h1A3); wait_txc(t1); clear_txc; step(2);
    chk(irq_rxc == 1'b1 && rx_data == 9'h1A3, "R9 address stored", int'(rx_data), 'h1A3);
    send(9'h033); wait_txc(t1); clear_txc; step(10);
    chk(rx_data == 9'h1A3 && rx_ovr == 1'b0, "R9 dropped frame leaves buffer", int'(rx_ovr), 0);
    read_rx;
    @(negedge clk); cfg_mp_en = 1'b0;
    xfer(9'h033, 4, 0, 0);
    // R9 at 7 bits: final bit is bit 6
    @(negedge clk); cfg_len = 3'd2; cfg_mp_en = 1'b1;
    send(9'h03F); wait_txc(t1); clear_txc; step(10);
    chk(irq_rxc == 1'b0, "R9 7-bit data frame dropped", int'(irq_rxc), 0);
    send(9'h041); wait_txc(t1); clear_txc; step(2);
    chk(rx_data == 9'h041, "R9 7-bit address stored", int'(rx_data), 'h041);
    read_rx;
    @(negedge clk); cfg_mp_en = 1'b0; cfg_len = 3'd3; loop_en = 1'b0;

    // R4 parity on hand-built frames (8 bits)
    d8 = 8'h35;
    @(negedge clk); cfg_par = 2'b10;
    fb = {5'b11111, 1'b1, ^d8, d8, 1'b0};
    raw_frame(fb, 11, 16'h0);
    chk(rx_perr == 1'b0 && rx_data == 9'h035, "R4 even parity accepted", int'(rx_perr), 0);
    read_rx;
    fb = {5'b11111, 1'b1, ~(^d8), d8, 1'b0};
    raw_frame(fb, 11, 16'h0);
    chk(rx_perr == 1'b1, "R4 wrong even parity flagged", int'(rx_perr), 1);
    chk(rx_data == 9'h035, "R4 word still delivered", int'(rx_data), 'h035);
    read_rx;
    @(negedge clk); cfg_par = 2'b11;
    fb = {5'b11111, 1'b1, ~(^d8), d8, 1'b0};
    raw_frame(fb, 11, 16'h0);
    chk(rx_perr == 1'b0, "R4 odd parity accepted", int'(rx_perr), 0);
    read_rx;

    // R5 framing error
    @(negedge clk); cfg_par = 2'b00;
    fb = {6'b111111, 1'b0, 8'h5C, 1'b0};
    raw_frame(fb, 10, 16'h0);
    chk(rx_ferr == 1'b1, "R5 framing error flagged", int'(rx_ferr), 1);
    chk(rx_data == 9'h05C, "R5 data delivered", int'(rx_data), 'h05C);
    read_rx;
    step(40);
    chk(irq_rxc == 1'b0, "R7 low stop not taken as frame", int'(irq_rxc), 0);

    // R7 false start
    @(negedge clk); drv_rxd = 1'b0;
    step(4);
    drv_rxd = 1'b1;
    step(300);
    chk(irq_rxc == 1'b0, "R7 false start ignored", int'(irq_rxc), 0);
    fb = {6'b111111, 1'b1, 8'h96, 1'b0};
    raw_frame(fb, 10, 16'h0);
    chk(rx_data == 9'h096 && irq_rxc, "R7 next frame intact", int'(rx_data), 'h096);
    read_rx;

    // R8 single-cycle glitches at start and data-bit centres
    fb = {6'b111111, 1'b1, 8'h00, 1'b0};
    raw_frame(fb, 10, 16'b0000_0000_0100_1001);
    chk(irq_rxc == 1'b1, "R8 glitched start still valid", int'(irq_rxc), 1);
    chk(rx_data == 9'h000, "R8 glitch voted out", int'(rx_data), 0);
    read_rx;
    fb = {6'b111111, 1'b1, 8'hFF, 1'b0};
    raw_frame(fb, 10, 16'b0000_0000_0001_0100);
    chk(rx_data == 9'h0FF && !rx_ferr, "R8 low glitch voted out", int'(rx_data), 'h0FF);
    read_rx;

    summary;
  end
endmodule